// File: doc/BRIEF.md
# Cyclic ADC Redundant-Digit Accumulator

This block is the digital back end of a cyclic analog-to-digital converter that resolves 1.5 bits per cycle. In each conversion cycle, two comparators report where the current residue lies relative to a positive and a negative quarter-reference threshold. The block turns that pair into a signed digit of +1, 0 or -1. In the same cycle, and without a register in the path, it tells the residue multiplier which reference operation to apply. It then adds the digit into an accumulator at a binary weight set by the cycle index.

The held input is swapped after the first cycle, so every residue seen from the second cycle on has the opposite polarity. The block corrects for this by negating every digit after the first. When the sequencer signals the closing cycle of the frame, the accumulated signed value is shifted to offset binary, clamped to the output range and registered. The result stays stable until the next frame's closing cycle. A level flag shows that at least one result has been produced. A sticky flag records any comparator pair that cannot occur.

Top module: `cyclic_digit_acc`

## Requirements
- R1: The comparator pair {cmp_hi, cmp_lo} decodes to a digit: 2'b11 is +1, 2'b01 is 0 and 2'b00 is -1. The impossible pair 2'b10 is treated as 0.
- R2: In a digit cycle (cap_en high and cyc_idx from 1 to 10), ref_sel is 2'b01 (subtract the reference) for digit +1, 2'b10 (add the reference) for digit -1 and 2'b00 for digit 0. It follows the comparator inputs in the same cycle. Outside digit cycles, ref_sel is 2'b00.
- R3: The digit captured at cyc_idx = k carries the weight 2^(10-k). The capture at cyc_idx = 1 replaces the accumulator contents instead of adding to them.
- R4: The digit of cycle 1 enters the sum with its own sign. Digits of cycles 2 to 10 enter with the opposite sign.
- R5: At the clock edge where cap_en is high and cyc_idx = 11, code is loaded with the accumulated sum plus 512 and code_vld goes high. code_vld then stays high until reset.
- R6: A sum plus 512 below 0 loads 0, and a value above 1023 loads 1023.
- R7: code changes only at a closing cycle (R5) or at reset.
- R8: While cap_en is low, or while cyc_idx is 0 or above 11, the comparator inputs change neither the accumulator, code, code_vld nor cmp_fault.
- R9: The pair 2'b10 in a digit cycle sets cmp_fault at the next clock edge. Only reset clears it.
- R10: An active-low asynchronous reset clears code, code_vld, cmp_fault and the accumulator.
- R11: When the comparators take ideal decisions on a residue that is doubled and reduced each cycle and inverted after cycle 1, for an input x in units of the reference, code lies within 1 LSB of floor(1024·x + 512) clamped to 0..1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_en | input | 1 | Capture enable from the sequencer |
| cyc_idx | input | 4 | Cycle index: 1..10 digit cycles, 11 closing cycle |
| cmp_hi | input | 1 | Comparator output, residue above +Vref/4 |
| cmp_lo | input | 1 | Comparator output, residue above -Vref/4 |
| ref_sel | output | 2 | Reference operation for the residue multiplier |
| code | output | 10 | Registered offset-binary result |
| code_vld | output | 1 | High once a result has been loaded |
| cmp_fault | output | 1 | Sticky flag for the impossible comparator pair |

## Verification
The bound checker watches every cycle for these properties: the reference select is at most one-hot, it stays idle when capture is off and it follows the decoded digit. The code holds outside closing cycles, the fault flag is set by the impossible pair and stays set, and the valid flag rises only after a closing cycle. The weighting, the sign flip after the swap, the clamp at both ends and the end-to-end accuracy against an ideal quantiser depend on a whole frame of decisions. Only the bench's scenarios show them: hand-picked digit patterns, inputs past full scale, and a sweep of real-valued inputs driven through a behavioural model of the residue loop.

// File: rtl/cyclic_digit_acc.sv
module cyclic_digit_acc #(
  parameter int NBITS = 10,
  parameter int IW = $clog2(NBITS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [IW-1:0]    cyc_idx,
  input  logic             cmp_hi,
  input  logic             cmp_lo,
  output logic [1:0]       ref_sel,
  output logic [NBITS-1:0] code,
  output logic             code_vld,
  output logic             cmp_fault
);
  localparam int ACCW = NBITS + 2;
  localparam logic signed [ACCW-1:0] MID = ACCW'(2 ** (NBITS - 1));
  localparam logic signed [ACCW-1:0] TOP = ACCW'(2 ** NBITS - 1);
  localparam logic [IW-1:0] LAST = IW'(NBITS);
  localparam logic [IW-1:0] FIN  = IW'(NBITS + 1);

  logic signed [ACCW-1:0] acc, wgt, term, biased;

  wire [1:0] cmp     = {cmp_hi, cmp_lo};
  wire       up      = (cmp == 2'b11);
  wire       dn      = (cmp == 2'b00);
  wire       bad     = (cmp == 2'b10);
  wire       first   = (cyc_idx == IW'(1));
  wire       dig_cyc = cap_en && (cyc_idx != '0) && (cyc_idx <= LAST);
  wire       fin_cyc = cap_en && (cyc_idx == FIN);

  assign ref_sel = dig_cyc ? {dn, up} : 2'b00;
  assign wgt     = ACCW'(1) << (LAST - cyc_idx);
  assign biased  = acc + MID;

  always_comb begin
    term = '0;
    if (up)      term = first ? wgt : -wgt;
    else if (dn) term = first ? -wgt : wgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      code      <= '0;
      code_vld  <= 1'b0;
      cmp_fault <= 1'b0;
    end else begin
      if (dig_cyc) acc <= first ? term : acc + term;
      if (dig_cyc && bad) cmp_fault <= 1'b1;
      if (fin_cyc) begin
        code_vld <= 1'b1;
        if (biased < 0)        code <= '0;
        else if (biased > TOP) code <= '1;
        else                   code <= biased[NBITS-1:0];
      end
    end
  end
endmodule

// File: rtl/cyclic_digit_acc_chk.sv
module cyclic_digit_acc_chk #(
  parameter int NBITS = 10,
  parameter int IW = $clog2(NBITS + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_en,
  input logic [IW-1:0]    cyc_idx,
  input logic             cmp_hi,
  input logic             cmp_lo,
  input logic [1:0]       ref_sel,
  input logic [NBITS-1:0] code,
  input logic             code_vld,
  input logic             cmp_fault
);
  wire in_dig = cap_en && (cyc_idx != '0) && (cyc_idx <= IW'(NBITS));
  wire in_fin = cap_en && (cyc_idx == IW'(NBITS + 1));

  assert_refsel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ref_sel));
  assert_refsel_plus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dig && cmp_hi && cmp_lo) |-> ref_sel == 2'b01);
  assert_refsel_minus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dig && !cmp_hi && !cmp_lo) |-> ref_sel == 2'b10);
  assert_refsel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> ref_sel == 2'b00);
  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_fin |=> $stable(code));
  assert_fault_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dig && cmp_hi && !cmp_lo) |=> cmp_fault);
  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fault |=> cmp_fault);
  assert_vld_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_vld) |-> $past(in_fin));
endmodule

bind cyclic_digit_acc cyclic_digit_acc_chk #(.NBITS(NBITS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cyc_idx(cyc_idx),
  .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .ref_sel(ref_sel), .code(code),
  .code_vld(code_vld), .cmp_fault(cmp_fault)
);

// File: tb/tb_cyclic_digit_acc.sv
module tb_cyclic_digit_acc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_en = 1'b0;
  logic [3:0] cyc_idx = '0;
  logic cmp_hi = 1'b0, cmp_lo = 1'b0;
  logic [1:0] ref_sel;
  logic [9:0] code;
  logic code_vld, cmp_fault;

  cyclic_digit_acc dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cyc_idx(cyc_idx),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .ref_sel(ref_sel), .code(code),
    .code_vld(code_vld), .cmp_fault(cmp_fault)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int m_acc = 0, m_code = 0, m_vld = 0, m_fault = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_code = 0; m_vld = 0; m_fault = 0;
  endtask

  task automatic step(input bit en, input int idx, input bit h, input bit l);
    int d, er, v;
    @(negedge clk);
    chk("R7 code", code, m_code);
    chk("R5 code_vld", code_vld, m_vld);
    chk("R9 cmp_fault", cmp_fault, m_fault);
    cap_en = en; cyc_idx = idx[3:0]; cmp_hi = h; cmp_lo = l;
    #1;
    d = (h && l) ? 1 : ((!h && !l) ? -1 : 0);
    er = 0;
    if (en && idx >= 1 && idx <= 10) er = (d == 1) ? 1 : ((d == -1) ? 2 : 0);
    chk("R1 R2 ref_sel", ref_sel, er);
    if (en && idx >= 1 && idx <= 10) begin
      if (h && !l) m_fault = 1;
      if (idx == 1) m_acc = d * 512;
      else m_acc = m_acc - d * (1 << (10 - idx));
    end
    if (en && idx == 11) begin
      v = m_acc + 512;
      if (v < 0) v = 0;
      if (v > 1023) v = 1023;
      m_code = v; m_vld = 1;
    end
    @(posedge clk);
  endtask

  // pat[k-1] is the comparator pair {hi,lo} of cycle k
  task automatic pat_frame(input logic [9:0][1:0] pat, input bit en, input string tag, input int exp);
    for (int k = 1; k <= 10; k++) step(en, k, pat[k-1][1], pat[k-1][0]);
    step(en, 11, 1'b0, 1'b0);
    #5;
    chk(tag, code, exp);
  endtask

  task automatic real_frame(input real x, input string tag);
    real a, v;
    int id;
    a = x;
    for (int k = 1; k <= 10; k++) begin
      bit h, l;
      int e;
      h = a > 0.25;
      l = a > -0.25;
      e = h ? 1 : (l ? 0 : -1);
      step(1'b1, k, h, l);
      a = 2.0 * a - e;
      if (k == 1) a = -a;
    end
    step(1'b1, 11, 1'b0, 1'b0);
    #5;
    v = x * 1024.0 + 512.0;
    id = int'($floor(v));
    if (id < 0) id = 0;
    if (id > 1023) id = 1023;
    n_chk++;
    if (int'(code) - id > 1 || id - int'(code) > 1) begin
      n_bad++;
      $display("FAIL %s x=%f: actual %0d expected %0d +-1", tag, x, code, id);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [9:0][1:0] p;
    repeat (2) @(negedge clk);
    chk("R10 reset code", code, 0);
    chk("R10 reset vld", code_vld, 0);
    chk("R10 reset fault", cmp_fault, 0);
    rst_n = 1'b1;

    // R3: first digit +1 alone weighs 512 -> 1024 clamps to 1023 (R6)
    for (int i = 0; i < 10; i++) p[i] = 2'b01;
    p[0] = 2'b11;
    pat_frame(p, 1'b1, "R3 R6 top clamp", 1023);
    // first digit -1 alone -> -512 + 512 = 0
    p[0] = 2'b00;
    pat_frame(p, 1'b1, "R3 first digit -1", 0);
    // R4: cycle 2 digit -1 is negated -> +256 -> 768
    for (int i = 0; i < 10; i++) p[i] = 2'b01;
    p[1] = 2'b00;
    pat_frame(p, 1'b1, "R4 negated cycle 2", 768);
    // R4: cycle 10 digit +1 negated -> -1 -> 511
    for (int i = 0; i < 10; i++) p[i] = 2'b01;
    p[9] = 2'b11;
    pat_frame(p, 1'b1, "R4 negated cycle 10", 511);
    // R4: +1 first then all +1 -> 512 - 511 = 1 -> 513
    for (int i = 0; i < 10; i++) p[i] = 2'b11;
    pat_frame(p, 1'b1, "R4 first kept later negated", 513);
    // R6: first -1 then all -1 after swap add +511 ... -512 - (-511) = -1 -> 511
    for (int i = 0; i < 10; i++) p[i] = 2'b00;
    pat_frame(p, 1'b1, "R3 R4 all minus", 511);
    // R6 bottom clamp: -512 then later +1 digits negated -> -1023 -> 0
    for (int i = 0; i < 10; i++) p[i] = 2'b11;
    p[0] = 2'b00;
    pat_frame(p, 1'b1, "R6 bottom clamp", 0);

    // R8: frame with capture disabled leaves code at 0, and bad pairs set no fault
    for (int i = 0; i < 10; i++) p[i] = 2'b10;
    p[0] = 2'b11;
    pat_frame(p, 1'b0, "R8 disabled frame", 0);
    chk("R8 no fault when disabled", cmp_fault, 0);
    // R8: out-of-range indices ignored
    step(1'b1, 0, 1'b1, 1'b0);
    step(1'b1, 12, 1'b1, 1'b0);
    step(1'b1, 15, 1'b0, 1'b0);
    #5;
    chk("R8 idx outside range code", code, 0);
    chk("R8 idx outside range fault", cmp_fault, 0);

    // R11: ideal comparator frames
    real_frame(0.0, "R11 zero");
    real_frame(0.123, "R11 small positive");
    real_frame(-0.377, "R11 negative");
    real_frame(0.4999, "R11 near top");
    real_frame(-0.5, "R11 bottom");
    real_frame(0.25, "R11 threshold");
    real_frame(-0.25, "R11 neg threshold");
    real_frame(0.9, "R6 R11 over range");
    real_frame(-0.9, "R6 R11 under range");
    for (int i = 0; i < 300; i++) real_frame(-0.55 + 1.1 * i / 299.0, "R11 sweep");

    // R7: code holds across idle cycles
    repeat (5) step(1'b0, 3, 1'b1, 1'b1);
    #5;
    chk("R7 hold after idle", code, m_code);

    // R9: impossible pair in cycle 5 acts as digit 0 and latches fault
    for (int i = 0; i < 10; i++) p[i] = 2'b01;
    p[0] = 2'b11;
    p[4] = 2'b10;
    pat_frame(p, 1'b1, "R1 R9 bad pair as zero", 1023);
    chk("R9 fault latched", cmp_fault, 1);
    repeat (3) step(1'b1, 4, 1'b0, 1'b1);
    #5;
    chk("R9 fault sticky", cmp_fault, 1);

    // R10: asynchronous reset mid-run
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk("R10 async code", code, 0);
    chk("R10 async vld", code_vld, 0);
    chk("R10 async fault", cmp_fault, 0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    real_frame(0.2, "R10 R11 after reset");
    step(1'b0, 0, 1'b0, 0'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule